// File: doc/BRIEF.md
# OSD Strip Descriptor Display Sequencer

This block lays out an on-screen display frame as a chain of horizontal strips. It reads the strips one after another from a table of 16-bit descriptors in RAM. A frame begins on the active edge of the vertical sync input. At that point the table pointer returns to the base of the selected page. Each active edge of the horizontal sync input then starts a new scan line. For that line the block decides whether the line belongs to a spacing strip, a shown character strip or a hidden character strip. When a strip has used up its lines, the next descriptor is fetched on demand.

For character strips the block stretches the 18 glyph slices over a programmable row height of CH lines. It picks the slice for each line by rounding the exact ratio, using a small sequential divider that runs during horizontal blanking. It hands the character-code start address, the slice number and a horizontal active window to a downstream pixel generator. It also tells that generator whether the fast-blank output must be forced for the line. All logic runs on the pixel clock.

Top module: `osd_strip_seq`

## Requirements
- R1: After reset, line_kind is 0 (no line), char_window, fblk_fill and ram_rd are low, and horizontal sync edges are ignored until the first vertical sync edge.
- R2: Each sync input has its own polarity bit (vsync_pol, hsync_pol). A value of 0 makes the falling edge active and a value of 1 makes the rising edge active. The inactive edge has no effect.
- R3: On a vertical sync edge, line_kind returns to 0. The first descriptor of the new frame is then read from RAM word address page_sel × 64, that is, page_sel in address bits 8:6 with all other bits zero.
- R4: A descriptor with bit 15 = 0 is a spacing strip. Its bits 7:0 give its length in lines, and a value of 0 counts as 1. Its lines report line_kind = 1, code_addr = 0 and slice_num = 0.
- R5: A descriptor with bit 15 = 1 is a character strip. In it, bit 14 is display enable, bit 13 is zoom and bits 9:1 give the even code start address (bit 0 is read as 0). Its lines report line_kind = 2 when enabled and 3 when disabled, with code_addr set to the start address.
- R6: A character strip lasts CH lines, or 2·CH lines with zoom. With zoom, each slice is shown on two consecutive lines. A char_height of 0 acts as 1.
- R7: On line index i of a character row (i counted after zoom halving), slice_num = floor((36·i + CH) / (2·CH)). This is i·18/CH rounded half up, and it never exceeds 18.
- R8: When a strip's last line has been issued, the next horizontal edge fetches the descriptor at the next RAM word address.
- R9: fblk_fill equals fast_blank on spacing lines and on disabled character lines. It is 0 on enabled character lines and when there is no line.
- R10: A pixel count restarts at 0 in the cycle that begins at the second rising clock edge after the horizontal sync input first shows its active level. char_window is high exactly while that count lies in [(h_delay+8)·3, (line_dur+1)·12), and only on enabled character lines.
- R11: Each line's outputs are settled before its window opens when h_delay ≥ 4: the window is never high while a descriptor fetch or slice division is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync_in | input | 1 | Vertical sync input |
| hsync_in | input | 1 | Horizontal sync input |
| vsync_pol | input | 1 | Vertical active edge: 0 falling, 1 rising |
| hsync_pol | input | 1 | Horizontal active edge: 0 falling, 1 rising |
| page_sel | input | 3 | Page holding the descriptor table |
| char_height | input | 6 | Character row height CH in lines |
| line_dur | input | 6 | Line length in units of 12 pixels, minus one |
| h_delay | input | 8 | Left margin in units of 3 pixels, minus eight |
| fast_blank | input | 1 | Force blanking outside characters |
| ram_rd | output | 1 | RAM read strobe |
| ram_addr | output | 10 | RAM word address of the descriptor |
| ram_rdata | input | 16 | RAM read data, valid one cycle after ram_rd |
| line_kind | output | 2 | 0 none, 1 spacing, 2 character shown, 3 character hidden |
| code_addr | output | 10 | Start address of the row's character codes |
| slice_num | output | 5 | Glyph slice for the current line |
| fblk_fill | output | 1 | Force fast blank for the whole line |
| char_window | output | 1 | Horizontal active window for character pixels |

## Verification
Some properties are checked on every cycle. The window never opens while the sequencer is busy. A published slice never exceeds 18. The divider always leaves a remainder below its divisor. The window is closed right after a line starts. The first fetch of a frame targets the page base. The bench scenarios are the only place to show the strip order through a table, the exact rounding of each slice for a height of 7 (with and without zoom), the restart of a table on a new vertical edge, the effect of the fast-blank bit, and the exact window position and width under both sync polarities.

// File: rtl/osd_seq_pkg.sv
package osd_seq_pkg;
    localparam int ADDR_W     = 10;
    localparam int DESC_W     = 16;
    localparam int CH_W       = 6;
    localparam int LD_W       = 6;
    localparam int DD_W       = 8;
    localparam int PAGE_W     = 3;
    localparam int PAGE_SHIFT = 6;
    localparam int SLICES     = 18;
    localparam int SLICE_W    = $clog2(SLICES + 1);
    localparam int LINE_W     = 9;
    localparam int NUM_W      = 12;
    localparam int DEN_W      = CH_W + 1;
    localparam int PIX_W      = 10;

    typedef enum logic [1:0] {
        LK_NONE     = 2'd0,
        LK_SPACE    = 2'd1,
        LK_CHAR_ON  = 2'd2,
        LK_CHAR_OFF = 2'd3
    } line_kind_e;

    typedef enum logic [2:0] {
        SQ_WAIT, SQ_FETCH, SQ_LOAD, SQ_CALC, SQ_DIV, SQ_PUB
    } seq_state_e;

    typedef struct packed {
        logic              is_char;
        logic              show;
        logic              zoom;
        logic [ADDR_W-1:0] code;
        logic [7:0]        lines;
    } strip_t;

    function automatic strip_t decode_desc(input logic [DESC_W-1:0] w);
        strip_t s;
        s.is_char = w[15];
        s.show    = w[14];
        s.zoom    = w[13];
        s.code    = {w[ADDR_W-1:1], 1'b0};
        s.lines   = w[7:0];
        return s;
    endfunction
endpackage

// File: rtl/osd_edge_sync.sv
module osd_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    input  logic rise_sel,
    output logic pulse
);
    logic norm, q1, q2;

    // Normalise so that the selected edge always appears as a rise.
    assign norm = rise_sel ? sig_in : ~sig_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            q1 <= 1'b1;
            q2 <= 1'b1;
        end else begin
            q1 <= norm;
            q2 <= q1;
        end
    end

    assign pulse = q1 & ~q2;
endmodule

// File: rtl/osd_round_div.sv
module osd_round_div #(
    parameter int NUM_W = 12,
    parameter int DEN_W = 7,
    parameter int OUT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [OUT_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] q;
    logic [DEN_W:0]   rem;
    logic [DEN_W-1:0] d;
    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic [DEN_W:0]   trial;

    assign trial = {rem[DEN_W-1:0], q[NUM_W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            rem  <= '0;
            d    <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                q    <= num;
                rem  <= '0;
                d    <= den;
                cnt  <= CNT_W'(NUM_W);
                busy <= 1'b1;
            end else if (busy) begin
                if (trial >= {1'b0, d}) begin
                    rem <= trial - {1'b0, d};
                    q   <= {q[NUM_W-2:0], 1'b1};
                end else begin
                    rem <= trial;
                    q   <= {q[NUM_W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q[OUT_W-1:0];

    // R7: a finished division leaves a remainder smaller than the divisor
    assert_rem_below_den_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (rem < {1'b0, d}));
    // R6: the divisor is never zero (a zero height is lifted to one)
    assert_den_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        start |-> (den != '0));
endmodule

// File: rtl/osd_hwindow.sv
module osd_hwindow #(
    parameter int LD_W  = 6,
    parameter int DD_W  = 8,
    parameter int PIX_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            line_start,
    input  logic [LD_W-1:0] line_dur,
    input  logic [DD_W-1:0] h_delay,
    output logic            in_window
);
    logic [PIX_W-1:0] cnt, len_c, start_c;

    assign len_c   = (PIX_W'(line_dur) + PIX_W'(1)) * PIX_W'(12);
    assign start_c = (PIX_W'(h_delay) + PIX_W'(8)) * PIX_W'(3);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '1;
        else if (line_start)
            cnt <= '0;
        else if (cnt < len_c)
            cnt <= cnt + 1'b1;
    end

    assign in_window = (cnt >= start_c) && (cnt < len_c);

    // R10: the window is closed in the first cycle of every line
    assert_window_late_R10: assert property (@(posedge clk)
        disable iff (rst || h_delay < DD_W'(4))
        line_start |=> !in_window);
endmodule

// File: rtl/osd_strip_seq.sv
module osd_strip_seq
    import osd_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vsync_in,
    input  logic              hsync_in,
    input  logic              vsync_pol,
    input  logic              hsync_pol,
    input  logic [PAGE_W-1:0] page_sel,
    input  logic [CH_W-1:0]   char_height,
    input  logic [LD_W-1:0]   line_dur,
    input  logic [DD_W-1:0]   h_delay,
    input  logic              fast_blank,
    output logic              ram_rd,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [DESC_W-1:0] ram_rdata,
    output logic [1:0]        line_kind,
    output logic [ADDR_W-1:0] code_addr,
    output logic [SLICE_W-1:0] slice_num,
    output logic              fblk_fill,
    output logic              char_window
);
    logic v_pulse, h_pulse, win, div_start, div_done;
    logic [SLICE_W-1:0] div_q;

    seq_state_e        state;
    strip_t            cur;
    logic [ADDR_W-1:0] ptr;
    logic              need, frame_on, first_fetch;
    logic [LINE_W-1:0] raw, idx, total_c;
    line_kind_e        k_q;
    logic [ADDR_W-1:0] code_q;
    logic [SLICE_W-1:0] slice_q;
    logic [CH_W-1:0]   ch_eff;
    logic [NUM_W-1:0]  numer;
    logic [DEN_W-1:0]  denom;

    osd_edge_sync u_vs (.clk(clk), .rst(rst), .sig_in(vsync_in), .rise_sel(vsync_pol), .pulse(v_pulse));
    osd_edge_sync u_hs (.clk(clk), .rst(rst), .sig_in(hsync_in), .rise_sel(hsync_pol), .pulse(h_pulse));

    osd_hwindow #(.LD_W(LD_W), .DD_W(DD_W), .PIX_W(PIX_W)) u_win (
        .clk(clk), .rst(rst), .line_start(h_pulse),
        .line_dur(line_dur), .h_delay(h_delay), .in_window(win));

    osd_round_div #(.NUM_W(NUM_W), .DEN_W(DEN_W), .OUT_W(SLICE_W)) u_div (
        .clk(clk), .rst(rst), .start(div_start), .num(numer), .den(denom),
        .done(div_done), .quot(div_q));

    // Effective height, strip length and rounding operands
    assign ch_eff  = (char_height == '0) ? CH_W'(1) : char_height;
    assign total_c = cur.is_char ? (cur.zoom ? LINE_W'({ch_eff, 1'b0}) : LINE_W'(ch_eff))
                                 : ((cur.lines == 8'd0) ? LINE_W'(1) : LINE_W'(cur.lines));
    assign idx     = cur.zoom ? (raw >> 1) : raw;
    assign numer   = NUM_W'(idx) * NUM_W'(2 * SLICES) + NUM_W'(ch_eff);
    assign denom   = DEN_W'({ch_eff, 1'b0});
    assign div_start = (state == SQ_CALC) && cur.is_char;

    assign ram_rd   = (state == SQ_FETCH);
    assign ram_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_WAIT;
            ptr         <= '0;
            need        <= 1'b1;
            frame_on    <= 1'b0;
            first_fetch <= 1'b0;
            cur         <= '0;
            raw         <= '0;
            k_q         <= LK_NONE;
            code_q      <= '0;
            slice_q     <= '0;
        end else if (v_pulse) begin
            state       <= SQ_WAIT;
            ptr         <= ADDR_W'(page_sel) << PAGE_SHIFT;
            need        <= 1'b1;
            frame_on    <= 1'b1;
            first_fetch <= 1'b1;
            k_q         <= LK_NONE;
        end else begin
            case (state)
                SQ_WAIT: begin
                    if (h_pulse && frame_on) begin
                        if (need) begin
                            state <= SQ_FETCH;
                        end else begin
                            raw   <= raw + 1'b1;
                            state <= SQ_CALC;
                        end
                    end
                end
                SQ_FETCH: state <= SQ_LOAD;
                SQ_LOAD: begin
                    cur         <= decode_desc(ram_rdata);
                    ptr         <= ptr + 1'b1;
                    raw         <= '0;
                    need        <= 1'b0;
                    first_fetch <= 1'b0;
                    state       <= SQ_CALC;
                end
                SQ_CALC: begin
                    need  <= (LINE_W'(raw + 1'b1) >= total_c);
                    state <= cur.is_char ? SQ_DIV : SQ_PUB;
                end
                SQ_DIV: if (div_done) state <= SQ_PUB;
                SQ_PUB: begin
                    if (!cur.is_char)  k_q <= LK_SPACE;
                    else if (cur.show) k_q <= LK_CHAR_ON;
                    else               k_q <= LK_CHAR_OFF;
                    code_q  <= cur.is_char ? cur.code : '0;
                    slice_q <= cur.is_char ? div_q : '0;
                    state   <= SQ_WAIT;
                end
                default: state <= SQ_WAIT;
            endcase
        end
    end

    assign line_kind   = k_q;
    assign code_addr   = code_q;
    assign slice_num   = slice_q;
    assign fblk_fill   = fast_blank && ((k_q == LK_SPACE) || (k_q == LK_CHAR_OFF));
    assign char_window = win && (k_q == LK_CHAR_ON);

    // R11: the window opens only once the line's outputs are published
    assert_window_idle_R11: assert property (@(posedge clk) disable iff (rst)
        char_window |-> (state == SQ_WAIT));
    // R7: a shown slice stays inside the glyph plus its shadow slice
    assert_slice_max_R7: assert property (@(posedge clk) disable iff (rst)
        (k_q == LK_CHAR_ON) |-> (slice_q <= SLICE_W'(SLICES)));
    // R3: the first read of a frame targets the selected page base
    assert_first_fetch_page_R3: assert property (@(posedge clk) disable iff (rst)
        (ram_rd && first_fetch) |-> (ram_addr == (ADDR_W'(page_sel) << PAGE_SHIFT)));
endmodule

// File: tb/tb_osd_strip_seq.sv
module tb_osd_strip_seq;
    typedef struct {
        int req;
        int kind;
        int code;
        int slice;
        int fblk;
        int wcnt;
        int wfirst;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vsync_in = 1'b1, hsync_in = 1'b1, vsync_pol = 1'b0, hsync_pol = 1'b0;
    logic [2:0] page_sel = 3'd1;
    logic [5:0] char_height = 6'd7;
    logic [5:0] line_dur = 6'd15;
    logic [7:0] h_delay = 8'd4;
    logic fast_blank = 1'b1;
    logic ram_rd;
    logic [9:0] ram_addr;
    logic [15:0] ram_rdata;
    logic [1:0] line_kind;
    logic [9:0] code_addr;
    logic [4:0] slice_num;
    logic fblk_fill, char_window;

    logic [15:0] mem [0:1023];
    int checks = 0, bad = 0;
    int cur_len = 192, cur_start = 36;
    exp_t expq[$];
    event line_end;
    int lc = 0, wcnt = 0, wfirst = -1;
    logic hs_prev = 1'b0;
    logic grab = 1'b0;
    int first_addr = -1;

    always #2 clk = ~clk;

    osd_strip_seq dut (
        .clk(clk), .rst(rst), .vsync_in(vsync_in), .hsync_in(hsync_in),
        .vsync_pol(vsync_pol), .hsync_pol(hsync_pol), .page_sel(page_sel),
        .char_height(char_height), .line_dur(line_dur), .h_delay(h_delay),
        .fast_blank(fast_blank), .ram_rd(ram_rd), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .line_kind(line_kind), .code_addr(code_addr),
        .slice_num(slice_num), .fblk_fill(fblk_fill), .char_window(char_window));

    always @(posedge clk) begin
        if (ram_rd) ram_rdata <= mem[ram_addr];
        if (ram_rd && grab) begin
            first_addr <= int'(ram_addr);
            grab <= 1'b0;
        end
    end

    // Window observer: line cycles counted from the first active sync level
    always @(negedge clk) begin
        logic act;
        act = hsync_pol ? hsync_in : ~hsync_in;
        if (act && !hs_prev) begin
            lc = 0; wcnt = 0; wfirst = -1;
        end else begin
            lc = lc + 1;
        end
        if (char_window) begin
            wcnt = wcnt + 1;
            if (wfirst < 0) wfirst = lc;
        end
        hs_prev = act;
    end

    task automatic chk(input int req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(line_end);
            if (expq.size() == 0) begin
                checks++; bad++;
                $display("FAIL R8 scoreboard actual=empty expected=item");
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(e.req, "line_kind", int'(line_kind), e.kind);
                chk(5, "code_addr", int'(code_addr), e.code);       // R5
                chk(7, "slice_num", int'(slice_num), e.slice);      // R7
                chk(9, "fblk_fill", int'(fblk_fill), e.fblk);       // R9
                chk(10, "window_width", wcnt, e.wcnt);               // R10
                chk(10, "window_first", wfirst, e.wfirst);           // R10
            end
        end
    end

    function automatic exp_t mk(int req, int kind, int code, int slice, int fblk, int win);
        exp_t e;
        e.req = req; e.kind = kind; e.code = code; e.slice = slice; e.fblk = fblk;
        e.wcnt   = win ? (cur_len - cur_start) : 0;
        e.wfirst = win ? (cur_start + 2) : -1;
        return e;
    endfunction

    task automatic run_line(input exp_t e);
        expq.push_back(e);
        @(posedge clk); #1 hsync_in = hsync_pol;
        repeat (2) @(posedge clk);
        #1 hsync_in = ~hsync_pol;
        repeat (cur_len + 4) @(posedge clk);
        #2 -> line_end;
    endtask

    task automatic do_vsync();
        grab = 1'b1;
        @(posedge clk); #1 vsync_in = vsync_pol;
        repeat (2) @(posedge clk);
        #1 vsync_in = ~vsync_pol;
        repeat (3) @(posedge clk);
        #1;
    endtask

    // R6/R7: expected rows of one character strip
    task automatic run_char(input int req, input int code, input int de, input int zy, input int ch);
        for (int ln = 0; ln < ch * (1 + zy); ln++) begin
            int i;
            int sl;
            i  = zy ? ln / 2 : ln;
            sl = (36 * i + ch) / (2 * ch);
            run_line(mk(req, de ? 2 : 3, code, sl, de ? 0 : int'(fast_blank), de));
        end
    endtask

    initial begin
        for (int a = 0; a < 1024; a++) mem[a] = 16'h0000;
        // Page 1 table (base 64)
        mem[64] = 16'h0002;   // R4 spacing, 2 lines
        mem[65] = 16'hC100;   // R5 shown, no zoom, codes at 0x100
        mem[66] = 16'hE121;   // R5/R6 shown, zoom, odd address read as 0x120
        mem[67] = 16'h8140;   // R5 hidden row
        mem[68] = 16'h0001;   // R8 spacing, 1 line
        // Page 2 table (base 128)
        mem[128] = 16'hC200;
        mem[129] = 16'h0001;

        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(1, "reset line_kind", int'(line_kind), 0);
        chk(1, "reset ram_rd", int'(ram_rd), 0);
        chk(1, "reset char_window", int'(char_window), 0);
        chk(1, "reset fblk_fill", int'(fblk_fill), 0);

        // R1: horizontal edges before any frame leave the line empty
        run_line(mk(1, 0, 0, 0, 0, 0));
        run_line(mk(1, 0, 0, 0, 0, 0));

        // Frame 1: falling edges, CH=7
        do_vsync();
        chk(3, "line_kind after vsync", int'(line_kind), 0);
        run_line(mk(4, 1, 0, 0, 1, 0));
        run_line(mk(4, 1, 0, 0, 1, 0));
        chk(3, "first fetch address", first_addr, 64);
        run_char(7, 256, 1, 0, 7);
        run_char(6, 288, 1, 1, 7);
        run_char(9, 320, 0, 0, 7);
        run_line(mk(8, 1, 0, 0, 1, 0));

        // R3: a new vertical edge restarts the same table
        do_vsync();
        chk(3, "line_kind after second vsync", int'(line_kind), 0);
        run_line(mk(3, 1, 0, 0, 1, 0));

        // Frame 2: rising edges (R2), page 2, CH=18, other window
        #1;
        vsync_pol = 1'b1; vsync_in = 1'b0;
        hsync_pol = 1'b1; hsync_in = 1'b0;
        page_sel = 3'd2; char_height = 6'd18; h_delay = 8'd20; line_dur = 6'd31;
        fast_blank = 1'b0;
        cur_len = 384; cur_start = 84;
        do_vsync();
        chk(3, "page 2 line_kind after vsync", int'(line_kind), 0);
        run_char(2, 512, 1, 0, 18);
        chk(3, "page 2 first fetch address", first_addr, 128);
        run_line(mk(9, 1, 0, 0, 0, 0));

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    // Watchdog (R11 stands as the timing requirement a hang would break)
    initial begin
        repeat (200000) @(posedge clk);
        checks++; bad++;
        $display("FAIL R11 watchdog actual=timeout expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule